// File: doc/BRIEF.md
# Byte-to-Word Data FIFO Engine

This block is the data path of a memory-card host controller. It sits between a 16-entry FIFO of 32-bit words and a card-side port that carries one byte per handshake. The host reaches the FIFO through a word push/pop port. The card reaches it through the engine, which packs or unpacks bytes in little-endian order. A control write selects the direction: receive (card to host) or transmit (host to card). The same control write can start a transfer. Starting a transfer loads a byte countdown from a 16-bit length register.

While a transfer runs, the engine counts bytes down to zero. In receive it packs card bytes into words. In transmit it pops words and sends their bytes, least significant first. When the count reaches zero the engine raises sticky end-of-transfer flags. It then drops its busy state by itself once the FIFO has drained. A set of level flags reports the FIFO state. Only the group that belongs to the current direction is shown. Host accesses that would overflow or underflow the FIFO are dropped and raise a sticky error.

Top module: `bw_data_engine`

## Requirements
- R1: The FIFO holds 16 words of 32 bits in circular order. `level_o` runs from 0 to 16. `host_rdata_o` always shows the oldest stored word. A push and a pop may happen in the same cycle.
- R2: A control write (`ctrl_wr_i`) sets the busy state to `ctrl_en_i` and the direction to `ctrl_dir_i` (1 = receive, 0 = transmit). When `ctrl_en_i` is 1, the write also loads the byte count from the 16-bit length register, which is written with `len_wr_i`, and discards any partly built or partly sent word.
- R3: In receive, `card_rx_ready_o` is high only while busy, byte count nonzero and FIFO not full. The k-th byte of each word (k = 0..3) lands in bits 8k+7..8k. A word is pushed after its fourth byte, or with zeros in its upper bytes when the byte count reaches zero.
- R4: In transmit, `card_tx_valid_o` is high while busy, byte count nonzero and either a partly sent word is held or the FIFO is not empty. Bytes leave least significant first. Each accepted byte lowers the count by one. Bytes of the last word past the count are discarded.
- R5: While busy with a byte count of zero, `data_end_o` and `block_end_o` are set. They stay set until a `clr_i` pulse.
- R6: Busy clears by itself one cycle after the byte count is zero and the FIFO is empty.
- R7: Each flag vector is {active, half, full, empty, available}, from bit 4 down to bit 0. Available means level nonzero, empty means level 0, full means level 16. Half means level >= 8 in the receive vector and level <= 8 in the transmit vector. Active equals busy. Only the vector of the current direction is driven; the other one reads 0.
- R8: In transmit direction the host may push, and a host pop has no effect. In receive direction the host may pop, and a host push has no effect. A push to a full FIFO or a pop from an empty FIFO is dropped and sets `err_o`, which stays set until `clr_i`.
- R9: `words_left_o` equals (remaining byte count + 3) shifted right by 2.
- R10: After reset the block is idle in transmit direction: count 0, FIFO empty, all sticky flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_wr_i | input | 1 | Write strobe for the length register |
| len_i | input | 16 | Transfer length in bytes |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Start/enable value for the control write |
| ctrl_dir_i | input | 1 | Direction value for the control write (1 receive, 0 transmit) |
| clr_i | input | 1 | Clears the sticky end and error flags |
| host_push_i | input | 1 | Host word push |
| host_wdata_i | input | 32 | Host word to push |
| host_pop_i | input | 1 | Host word pop |
| host_rdata_o | output | 32 | Oldest word in the FIFO |
| card_rx_valid_i | input | 1 | Card byte offered |
| card_rx_byte_i | input | 8 | Card byte |
| card_rx_ready_o | output | 1 | Engine accepts the card byte |
| card_tx_valid_o | output | 1 | Engine offers a byte to the card |
| card_tx_byte_o | output | 8 | Byte to the card |
| card_tx_ready_i | input | 1 | Card accepts the byte |
| busy_o | output | 1 | Transfer enabled |
| remain_o | output | 16 | Remaining byte count |
| words_left_o | output | 15 | Remaining count in words, rounded up |
| level_o | output | 5 | FIFO fill level |
| rx_flags_o | output | 5 | Receive flag vector |
| tx_flags_o | output | 5 | Transmit flag vector |
| data_end_o | output | 1 | Sticky data-end flag |
| block_end_o | output | 1 | Sticky block-end flag |
| err_o | output | 1 | Sticky overflow/underflow error |

## Verification
Every length from 0 to 64 bytes runs in both directions. This covers every remainder modulo 4, which shows whether the final partial word is zero-padded on receive and truncated on transmit. Each byte value depends on both its index and the length, so a swapped byte lane or a stale word from an earlier run shows up as a miscompare. A 68-byte receive fills the FIFO mid-transfer and checks the stall against the count. A fill to 16 words followed by one extra push, a pop in the wrong direction and a pop from empty separates dropped accesses from accepted ones.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
  localparam int unsigned FLG_AVAIL  = 0;
  localparam int unsigned FLG_EMPTY  = 1;
  localparam int unsigned FLG_FULL   = 2;
  localparam int unsigned FLG_HALF   = 3;
  localparam int unsigned FLG_ACTIVE = 4;
  localparam int unsigned FLG_W      = 5;
endpackage

// File: rtl/bw_word_fifo.sv
module bw_word_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              drop_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              full, empty, do_push, do_pop;

  assign full    = lvl_q == LVL_W'(DEPTH);
  assign empty   = lvl_q == '0;
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign drop_o  = (push_i && full) || (pop_i && empty);
  assign rdata_o = mem_q[rd_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  // pointers wrap naturally; DEPTH is a power of two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end
endmodule

// File: rtl/bw_rx_pack.sv
module bw_rx_pack #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BYTES = WORD_W / 8,
  localparam int unsigned BI_W  = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic [7:0]        byte_i,
  input  logic              last_i,
  output logic [WORD_W-1:0] word_o,
  output logic              push_o
);
  logic [WORD_W-1:0] acc_q;
  logic [BI_W-1:0]   bidx_q;

  assign word_o = acc_q | (WORD_W'(byte_i) << {bidx_q, 3'b000});
  assign push_o = take_i && (bidx_q == BI_W'(BYTES - 1) || last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      bidx_q <= '0;
    end else if (clear_i || push_o) begin
      acc_q  <= '0;
      bidx_q <= '0;
    end else if (take_i) begin
      acc_q  <= word_o;
      bidx_q <= bidx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bw_tx_unpack.sv
module bw_tx_unpack #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BYTES = WORD_W / 8,
  localparam int unsigned BI_W  = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              head_ok_i,
  input  logic              send_i,
  input  logic              last_i,
  output logic [7:0]        byte_o,
  output logic              avail_o,
  output logic              pop_o
);
  logic [WORD_W-1:0] hold_q, src, sh;
  logic [BI_W-1:0]   bidx_q;
  logic              have_q;

  assign src     = have_q ? hold_q : head_i;
  assign sh      = src >> {bidx_q, 3'b000};
  assign byte_o  = sh[7:0];
  assign avail_o = have_q || head_ok_i;
  assign pop_o   = send_i && !have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      bidx_q <= '0;
      have_q <= 1'b0;
    end else if (clear_i) begin
      bidx_q <= '0;
      have_q <= 1'b0;
    end else if (send_i) begin
      if (!have_q) hold_q <= head_i;
      if (bidx_q == BI_W'(BYTES - 1) || last_i) begin
        bidx_q <= '0;
        have_q <= 1'b0;
      end else begin
        bidx_q <= bidx_q + 1'b1;
        have_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bw_flags.sv
module bw_flags import bw_pkg::*; #(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic             active_i,
  input  logic             dir_rx_i,
  output logic [FLG_W-1:0] rx_flags_o,
  output logic [FLG_W-1:0] tx_flags_o
);
  logic [FLG_W-1:0] rx_all, tx_all;

  always_comb begin
    rx_all = '0;
    rx_all[FLG_AVAIL]  = level_i != '0;
    rx_all[FLG_EMPTY]  = level_i == '0;
    rx_all[FLG_FULL]   = level_i == LVL_W'(DEPTH);
    rx_all[FLG_ACTIVE] = active_i;
    tx_all = rx_all;
    rx_all[FLG_HALF]   = level_i >= LVL_W'(DEPTH / 2);
    tx_all[FLG_HALF]   = level_i <= LVL_W'(DEPTH / 2);
  end

  assign rx_flags_o = dir_rx_i ? rx_all : '0;
  assign tx_flags_o = dir_rx_i ? '0 : tx_all;
endmodule

// File: rtl/bw_data_engine.sv
module bw_data_engine import bw_pkg::*; #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1,
  localparam int unsigned BI_W  = $clog2(WORD_W / 8),
  localparam int unsigned WL_W  = LEN_W - BI_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              len_wr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_dir_i,
  input  logic              clr_i,
  input  logic              host_push_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              host_pop_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              card_rx_valid_i,
  input  logic [7:0]        card_rx_byte_i,
  output logic              card_rx_ready_o,
  output logic              card_tx_valid_o,
  output logic [7:0]        card_tx_byte_o,
  input  logic              card_tx_ready_i,
  output logic              busy_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic [WL_W-1:0]   words_left_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [FLG_W-1:0]  rx_flags_o,
  output logic [FLG_W-1:0]  tx_flags_o,
  output logic              data_end_o,
  output logic              block_end_o,
  output logic              err_o
);
  logic              en_q, end_q, blk_q, err_q;
  dir_e              dir_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              is_rx, cnt_zero, last, restart;
  logic              rx_take, rx_push, tx_send, tx_pop, tx_avail;
  logic              f_push, f_pop, f_drop, f_full, f_empty;
  logic [WORD_W-1:0] rx_word, f_wdata;
  logic [LEN_W:0]    wl_sum;

  assign is_rx    = dir_q == DIR_RX;
  assign cnt_zero = cnt_q == '0;
  assign last     = cnt_q == LEN_W'(1);
  assign restart  = ctrl_wr_i && ctrl_en_i;
  assign f_full   = level_o == LVL_W'(DEPTH);
  assign f_empty  = level_o == '0;

  assign card_rx_ready_o = en_q && is_rx && !cnt_zero && !f_full;
  assign rx_take         = card_rx_valid_i && card_rx_ready_o;
  assign card_tx_valid_o = en_q && !is_rx && !cnt_zero && tx_avail;
  assign tx_send         = card_tx_valid_o && card_tx_ready_i;

  // host owns the FIFO end that the engine does not use
  assign f_push  = is_rx ? rx_push : host_push_i;
  assign f_wdata = is_rx ? rx_word : host_wdata_i;
  assign f_pop   = is_rx ? host_pop_i : tx_pop;

  bw_word_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (f_push),
    .wdata_i(f_wdata),
    .pop_i  (f_pop),
    .rdata_o(host_rdata_o),
    .level_o(level_o),
    .drop_o (f_drop)
  );

  bw_rx_pack #(.WORD_W(WORD_W)) u_pack (
    .clk_i, .rst_ni,
    .clear_i(restart),
    .take_i (rx_take),
    .byte_i (card_rx_byte_i),
    .last_i (last),
    .word_o (rx_word),
    .push_o (rx_push)
  );

  bw_tx_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk_i, .rst_ni,
    .clear_i  (restart),
    .head_i   (host_rdata_o),
    .head_ok_i(!f_empty),
    .send_i   (tx_send),
    .last_i   (last),
    .byte_o   (card_tx_byte_o),
    .avail_o  (tx_avail),
    .pop_o    (tx_pop)
  );

  bw_flags #(.DEPTH(DEPTH)) u_flags (
    .level_i   (level_o),
    .active_i  (en_q),
    .dir_rx_i  (is_rx),
    .rx_flags_o(rx_flags_o),
    .tx_flags_o(tx_flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dir_q <= DIR_TX;
      len_q <= '0;
      cnt_q <= '0;
      end_q <= 1'b0;
      blk_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (len_wr_i) len_q <= len_i;
      if (ctrl_wr_i) begin
        en_q  <= ctrl_en_i;
        dir_q <= dir_e'(ctrl_dir_i);
      end else if (en_q && cnt_zero && f_empty) begin
        en_q <= 1'b0;
      end
      if (restart) cnt_q <= len_q;
      else if (rx_take || tx_send) cnt_q <= cnt_q - 1'b1;
      if (en_q && cnt_zero) begin
        end_q <= 1'b1;
        blk_q <= 1'b1;
      end else if (clr_i) begin
        end_q <= 1'b0;
        blk_q <= 1'b0;
      end
      if (f_drop) err_q <= 1'b1;
      else if (clr_i) err_q <= 1'b0;
    end
  end

  assign wl_sum       = {1'b0, cnt_q} + (LEN_W + 1)'((1 << BI_W) - 1);
  assign words_left_o = wl_sum[LEN_W:BI_W];
  assign busy_o       = en_q;
  assign remain_o     = cnt_q;
  assign data_end_o   = end_q;
  assign block_end_o  = blk_q;
  assign err_o        = err_q;
endmodule

// File: rtl/bw_data_engine_chk.sv
module bw_data_engine_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr_i,
  input logic             clr_i,
  input logic             card_rx_ready_o,
  input logic             card_tx_valid_o,
  input logic             card_tx_ready_i,
  input logic             busy_o,
  input logic [LEN_W-1:0] remain_o,
  input logic [LVL_W-1:0] level_o,
  input logic [4:0]       rx_flags_o,
  input logic [4:0]       tx_flags_o,
  input logic             data_end_o,
  input logic             err_o
);
  a_r1_level_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  a_r3_no_accept_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rx_ready_o |-> level_o != LVL_W'(DEPTH));

  a_r4_count_per_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_tx_valid_o && card_tx_ready_i && !ctrl_wr_i |=> remain_o == LEN_W'($past(remain_o) - 1'b1));

  a_r5_end_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && remain_o == '0 |=> data_end_o);

  a_r6_self_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && remain_o == '0 && level_o == '0 && !ctrl_wr_i |=> !busy_o);

  a_r7_one_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flags_o == '0 || tx_flags_o == '0);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o);
endmodule

bind bw_data_engine bw_data_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctrl_wr_i      (ctrl_wr_i),
  .clr_i          (clr_i),
  .card_rx_ready_o(card_rx_ready_o),
  .card_tx_valid_o(card_tx_valid_o),
  .card_tx_ready_i(card_tx_ready_i),
  .busy_o         (busy_o),
  .remain_o       (remain_o),
  .level_o        (level_o),
  .rx_flags_o     (rx_flags_o),
  .tx_flags_o     (tx_flags_o),
  .data_end_o     (data_end_o),
  .err_o          (err_o)
);

// File: tb/bw_data_engine_bench.sv
module bw_data_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        len_wr_i = 0, ctrl_wr_i = 0, ctrl_en_i = 0, ctrl_dir_i = 0, clr_i = 0;
  logic [15:0] len_i = '0;
  logic        host_push_i = 0, host_pop_i = 0;
  logic [31:0] host_wdata_i = '0, host_rdata_o;
  logic        card_rx_valid_i = 0, card_rx_ready_o;
  logic [7:0]  card_rx_byte_i = '0, card_tx_byte_o;
  logic        card_tx_valid_o, card_tx_ready_i = 0;
  logic        busy_o, data_end_o, block_end_o, err_o;
  logic [15:0] remain_o;
  logic [14:0] words_left_o;
  logic [4:0]  level_o, rx_flags_o, tx_flags_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  bw_data_engine u_bw_data_engine (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int i, input int len);
    return 8'(i * 29 + len * 7 + 3);
  endfunction

  function automatic logic [31:0] rx_word(input int j, input int len);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (4 * j + k < len) w[8*k +: 8] = fb(4 * j + k, len);
    return w;
  endfunction

  function automatic logic [4:0] flags(input int lvl, input logic act, input logic rx);
    logic [4:0] f;
    f[0] = lvl != 0;
    f[1] = lvl == 0;
    f[2] = lvl == 16;
    f[3] = rx ? (lvl >= 8) : (lvl <= 8);
    f[4] = act;
    return f;
  endfunction

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_len(input int len);
    len_i = 16'(len); len_wr_i = 1; cyc(); len_wr_i = 0;
  endtask

  task automatic ctrl(input logic en, input logic dir);
    ctrl_en_i = en; ctrl_dir_i = dir; ctrl_wr_i = 1; cyc(); ctrl_wr_i = 0;
  endtask

  task automatic clear();
    clr_i = 1; cyc(); clr_i = 0;
  endtask

  task automatic push(input logic [31:0] w);
    host_wdata_i = w; host_push_i = 1; cyc(); host_push_i = 0;
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    chk(req, host_rdata_o, exp);
    host_pop_i = 1; cyc(); host_pop_i = 0;
  endtask

  task automatic rx_feed(input int from, input int to, input int len);
    int idx = from;
    int guard = 0;
    while (idx < to && guard < 1000) begin
      logic acc;
      card_rx_valid_i = 1;
      card_rx_byte_i = fb(idx, len);
      #1;
      acc = card_rx_ready_o;
      cyc();
      if (acc) idx++;
      guard++;
    end
    card_rx_valid_i = 0;
  endtask

  task automatic rx_run(input int len);
    int nw = (len + 3) / 4;
    set_len(len);
    ctrl(1, 1);
    chk("R2 count loaded", remain_o, 64'(len));
    chk("R9 words left", words_left_o, 64'((len + 3) >> 2));
    rx_feed(0, len, len);
    cyc(2);
    chk("R3 level after receive", level_o, 64'(nw));
    chk("R5 data end", data_end_o, 1);
    chk("R5 block end", block_end_o, 1);
    chk("R7 rx flags", rx_flags_o, 64'(flags(nw, len != 0, 1'b1)));
    chk("R7 tx group silent", tx_flags_o, 0);
    for (int j = 0; j < nw; j++) pop_chk("R3 packed word", rx_word(j, len));
    cyc(2);
    chk("R6 busy clears", busy_o, 0);
    clear();
    chk("R5 cleared", data_end_o, 0);
  endtask

  task automatic tx_run(input int len);
    int nw = (len + 3) / 4;
    int idx = 0;
    int guard = 0;
    ctrl(0, 0);
    for (int j = 0; j < nw; j++) begin
      logic [31:0] w;
      for (int k = 0; k < 4; k++)
        w[8*k +: 8] = (4 * j + k < len) ? fb(4 * j + k, len) : 8'hEE;
      push(w);
    end
    chk("R8 host push in transmit", level_o, 64'(nw));
    set_len(len);
    ctrl(1, 0);
    chk("R2 count loaded", remain_o, 64'(len));
    card_tx_ready_i = 1;
    while (idx < len && guard < 1000) begin
      if (card_tx_valid_o) begin
        chk("R4 byte order", card_tx_byte_o, 64'(fb(idx, len)));
        idx++;
      end
      cyc();
      guard++;
    end
    chk("R4 byte total", idx, len);
    card_tx_ready_i = 0;
    cyc(2);
    chk("R4 valid drops", card_tx_valid_o, 0);
    chk("R4 fifo drained", level_o, 0);
    chk("R6 busy clears", busy_o, 0);
    chk("R5 data end", data_end_o, 1);
    chk("R7 tx flags", tx_flags_o, 64'(flags(0, 1'b0, 1'b0)));
    clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(2);
    rst_ni = 1;
    cyc();
    // R10 reset state
    chk("R10 busy", busy_o, 0);
    chk("R10 level", level_o, 0);
    chk("R10 remain", remain_o, 0);
    chk("R10 tx flags", tx_flags_o, 5'b01010);
    chk("R10 rx flags", rx_flags_o, 0);
    chk("R10 sticky", {data_end_o, block_end_o, err_o}, 0);
    chk("R10 card idle", {card_tx_valid_o, card_rx_ready_o}, 0);

    // R1 / R8: fill, overflow, wrong-direction pop, drain, underflow
    for (int j = 0; j < 16; j++) begin
      push(32'h1000_0000 + 32'(j * 3));
      chk("R7 tx flags during fill", tx_flags_o, 64'(flags(j + 1, 1'b0, 1'b0)));
    end
    chk("R1 full level", level_o, 16);
    chk("R8 no error yet", err_o, 0);
    push(32'hDEAD_BEEF);
    chk("R8 overflow dropped", level_o, 16);
    chk("R8 overflow error", err_o, 1);
    clear();
    chk("R8 error cleared", err_o, 0);
    host_pop_i = 1; cyc(); host_pop_i = 0;
    chk("R8 pop ignored in transmit", level_o, 16);
    chk("R8 no error for ignored pop", err_o, 0);
    ctrl(0, 1);
    push(32'h0BAD_0BAD);
    chk("R8 push ignored in receive", level_o, 16);
    for (int j = 0; j < 16; j++) pop_chk("R1 order", 32'h1000_0000 + 32'(j * 3));
    chk("R1 empty", level_o, 0);
    host_pop_i = 1; cyc(); host_pop_i = 0;
    chk("R8 underflow error", err_o, 1);
    chk("R8 underflow level", level_o, 0);
    clear();

    for (int len = 0; len <= 64; len++) rx_run(len);
    for (int len = 0; len <= 64; len++) tx_run(len);

    // R3 stall on full FIFO mid-transfer
    set_len(68);
    ctrl(1, 1);
    rx_feed(0, 64, 68);
    card_rx_valid_i = 1;
    #1;
    chk("R3 stall when full", card_rx_ready_o, 0);
    card_rx_valid_i = 0;
    chk("R3 count at stall", remain_o, 4);
    chk("R9 words at stall", words_left_o, 1);
    chk("R7 rx full flags", rx_flags_o, 5'b11101);
    pop_chk("R3 first word", rx_word(0, 68));
    rx_feed(64, 68, 68);
    cyc(2);
    chk("R3 level after resume", level_o, 16);
    for (int j = 1; j < 17; j++) pop_chk("R3 word after stall", rx_word(j, 68));
    cyc(2);
    chk("R6 busy clears after stall", busy_o, 0);
    clear();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule